// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial memory's bus front end and its nonvolatile array. During a write transaction the front end hands it data bytes, each with an offset inside the current page. The block keeps them in a page-sized buffer and tracks which offsets were touched. When the transaction ends with a stop, it issues one array write. That write carries a byte-enable mask, so only the loaded bytes change. It then holds a busy flag for a programmable number of cycles, which models the self-timed program interval.

A transaction-start strobe clears the touched-byte mask. The page row is captured with the first byte loaded after that. Offsets are a fixed number of bits, so a run of loads longer than the page wraps back to offset 0, and a later byte to the same offset replaces the earlier one. A stop with nothing loaded does not start a write. This is the case of an address-only "dummy" write that comes before a random read. A stop with write protect high does not start a write either. In both cases the block goes straight back to idle with an empty mask.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy`, `arr_strobe` and `arr_we` are all zero.
- R2: A `stop_commit` accepted while idle, with at least one byte loaded and `wp` low, raises `arr_strobe` for exactly one cycle in the cycle after the stop. In that cycle `arr_data` bits [8i+7:8i] hold the byte loaded at offset i.
- R3: During the strobe, bit i of `arr_we` is 1 exactly when offset i was loaded in this transaction. Outside the strobe, `arr_we` is zero.
- R4: When the same offset is loaded more than once, the commit carries the last byte loaded there. This includes a run of loads that wraps past the page end back to offset 0.
- R5: `arr_row` equals the `row_addr` presented with the first load of the transaction. Later changes of `row_addr` have no effect.
- R6: A stop with no byte loaded produces no strobe and no busy.
- R7: A stop with `wp` high produces no strobe and no busy. It discards the loaded bytes.
- R8: `busy` rises in the same cycle as `arr_strobe` and stays high for exactly BUSY_CYCLES cycles.
- R9: While `busy` is high, all of `txn_start`, `ld_valid` and `stop_commit` are ignored. A stop after the window, with no new loads, commits nothing.
- R10: `txn_start` clears the mask, so bytes loaded before it are not committed.
- R11: A load presented in the same cycle as the accepted stop is part of the commit.
- R12: A load presented in the same cycle as `txn_start` counts as the first load of the new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Start of a write transaction; clears the mask |
| ld_valid | input | 1 | Byte load strobe |
| ld_offset | input | $clog2(PAGE_BYTES) | Offset of the byte within the page |
| ld_data | input | 8 | Byte to load |
| row_addr | input | ROW_W | Page row address, captured on the first load |
| stop_commit | input | 1 | Stop that ends the transaction; requests the commit |
| wp | input | 1 | Write protect; high blocks the commit |
| arr_we | output | PAGE_BYTES | Per-byte write enables to the array |
| arr_data | output | 8*PAGE_BYTES | Page data, byte i at bits [8i+7:8i] |
| arr_row | output | ROW_W | Row being written |
| arr_strobe | output | 1 | One-cycle array write pulse |
| busy | output | 1 | Self-timed write window in progress |

## Verification
Two things can land on the same clock edge here. The first is the stop that closes a transaction arriving together with its final byte load. The second is a transaction start arriving together with the first byte of the next transaction. The bench drives each pair in a single cycle. Its reference model applies the clear before the load, and the load before the commit. It then judges the enable mask, the data bytes and the row seen during the strobe against that model. Random runs also fire loads, starts and stops throughout the busy window. A later empty stop must then commit nothing.

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
  parameter int PAGE_BYTES  = 16,
  parameter int ROW_W       = 7,
  parameter int BUSY_CYCLES = 625000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          txn_start,
  input  logic                          ld_valid,
  input  logic [$clog2(PAGE_BYTES)-1:0] ld_offset,
  input  logic [7:0]                    ld_data,
  input  logic [ROW_W-1:0]              row_addr,
  input  logic                          stop_commit,
  input  logic                          wp,
  output logic [PAGE_BYTES-1:0]         arr_we,
  output logic [8*PAGE_BYTES-1:0]       arr_data,
  output logic [ROW_W-1:0]              arr_row,
  output logic                          arr_strobe,
  output logic                          busy
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [PAGE_BYTES-1:0] mask_q, mask_eff, ld_hot, mask_nx;
  logic [7:0]            page_q [PAGE_BYTES];
  logic [CNT_W-1:0]      cnt_q;
  logic                  idle, commit, do_write;

  assign idle     = !busy;
  assign mask_eff = txn_start ? '0 : mask_q;
  assign ld_hot   = ld_valid ? (PAGE_BYTES'(1) << ld_offset) : '0;
  assign mask_nx  = mask_eff | ld_hot;
  assign commit   = idle && stop_commit;
  assign do_write = commit && (|mask_nx) && !wp;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_out
    assign arr_data[8*i +: 8] = page_q[i];
  end

  always_ff @(posedge clk) begin
    if (idle && ld_valid) page_q[ld_offset] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      arr_row    <= '0;
      arr_we     <= '0;
      arr_strobe <= 1'b0;
      busy       <= 1'b0;
      cnt_q      <= '0;
    end else begin
      arr_we     <= '0;
      arr_strobe <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end else begin
        if (ld_valid && mask_eff == '0) arr_row <= row_addr;
        mask_q <= commit ? '0 : mask_nx;
        if (do_write) begin
          arr_strobe <= 1'b1;
          arr_we     <= mask_nx;
          busy       <= 1'b1;
          cnt_q      <= CNT_W'(BUSY_CYCLES - 1);
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{OFS_W};
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int PAGE_BYTES  = 16,
  parameter int ROW_W       = 7,
  parameter int BUSY_CYCLES = 625000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  stop_commit,
  input logic                  wp,
  input logic [PAGE_BYTES-1:0] arr_we,
  input logic [ROW_W-1:0]      arr_row,
  input logic                  arr_strobe,
  input logic                  busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 2);
  logic [CW-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win <= '0;
    else if (arr_strobe) win <= CW'(1);
    else if (busy)       win <= win + 1'b1;
  end

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_strobe |=> !arr_strobe);
  p_we_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_strobe |-> arr_we == '0);
  p_we_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_strobe |-> arr_we != '0);
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_commit && wp && !busy) |=> !arr_strobe);
  p_busy_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_strobe |-> busy);
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arr_strobe);
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> win == CW'(BUSY_CYCLES));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !arr_strobe);
  p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(arr_row));
endmodule

bind pgwr_commit pgwr_commit_chk #(
  .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (.*);

// File: tb/pgwr_commit_tb.sv
module pgwr_commit_tb;
  localparam int PB = 16, RW = 7, BZ = 23, OW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic txn_start = 0, ld_valid = 0, stop_commit = 0, wp = 0;
  logic [OW-1:0] ld_offset = '0;
  logic [7:0] ld_data = '0;
  logic [RW-1:0] row_addr = '0;
  logic [PB-1:0] arr_we;
  logic [8*PB-1:0] arr_data;
  logic [RW-1:0] arr_row;
  logic arr_strobe, busy;

  pgwr_commit #(.PAGE_BYTES(PB), .ROW_W(RW), .BUSY_CYCLES(BZ)) u_dut (.*);

  int checks = 0, fails = 0;
  logic [PB-1:0] m_mask = '0;
  logic [7:0] m_buf [PB];
  logic [RW-1:0] m_row = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void mload(input logic [OW-1:0] o, input logic [7:0] d, input logic [RW-1:0] r);
    if (m_mask == '0) m_row = r;
    m_buf[o] = d;
    m_mask[o] = 1'b1;
  endfunction

  task automatic load(input logic [OW-1:0] o, input logic [7:0] d, input logic [RW-1:0] r);
    ld_valid = 1; ld_offset = o; ld_data = d; row_addr = r;
    @(negedge clk);
    ld_valid = 0;
    mload(o, d, r);
  endtask

  task automatic txn(input bit with_ld, input logic [OW-1:0] o, input logic [7:0] d, input logic [RW-1:0] r);
    txn_start = 1;
    ld_valid = with_ld; ld_offset = o; ld_data = d; row_addr = r;
    @(negedge clk);
    txn_start = 0; ld_valid = 0;
    m_mask = '0;
    if (with_ld) mload(o, d, r);
  endtask

  task automatic commit(input bit p, input string tag, input bit with_ld,
                        input logic [OW-1:0] o, input logic [7:0] d, input logic [RW-1:0] r);
    bit exp;
    int n;
    stop_commit = 1; wp = p;
    ld_valid = with_ld; ld_offset = o; ld_data = d; row_addr = r;
    if (with_ld) mload(o, d, r);
    @(negedge clk);
    stop_commit = 0; wp = 0; ld_valid = 0;
    exp = (m_mask != '0) && !p;
    chk(arr_strobe == exp, {tag, " strobe"}, int'(arr_strobe), int'(exp));
    if (exp) begin
      chk(arr_we == m_mask, {tag, " R3 mask"}, int'(arr_we), int'(m_mask));
      for (int i = 0; i < PB; i++)
        if (m_mask[i]) chk(arr_data[8*i +: 8] == m_buf[i], {tag, " R4 data"},
                           int'(arr_data[8*i +: 8]), int'(m_buf[i]));
      chk(arr_row == m_row, {tag, " R5 row"}, int'(arr_row), int'(m_row));
      n = 0;
      while (busy && n < 10*BZ) begin
        n++;
        ld_valid = 1'($urandom); txn_start = 1'($urandom);
        stop_commit = 1'($urandom); wp = 1'($urandom);
        ld_offset = OW'($urandom); ld_data = 8'($urandom); row_addr = RW'($urandom);
        @(negedge clk);
        if (busy) chk(arr_strobe == 0, "R9 strobe in busy", int'(arr_strobe), 0);
      end
      ld_valid = 0; txn_start = 0; stop_commit = 0; wp = 0;
      chk(n == BZ, "R8 busy length", n, BZ);
    end else begin
      chk(busy == 0, {tag, " no busy"}, int'(busy), 0);
    end
    m_mask = '0;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < PB; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && arr_strobe == 0 && arr_we == '0, "R1 reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && arr_strobe == 0, "R1 after release", int'(busy), 0);

    txn(0, 0, 0, 0);
    load(3, 8'hA5, 7'd9); load(7, 8'h3C, 7'd9); load(12, 8'h81, 7'd9);
    commit(0, "R2 R3 partial", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) load(OW'(i), 8'(i + 100), 7'd33);
    load(2, 8'hEE, 7'd33);
    commit(0, "R4 wrap", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    load(5, 8'h11, 7'd70); load(6, 8'h22, 7'd3); load(1, 8'h33, 7'd99);
    commit(0, "R5 row", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    commit(0, "R6 empty", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    load(0, 8'h55, 7'd4);
    commit(1, "R7 wp", 0, 0, 0, 0);
    commit(0, "R7 discarded", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    load(9, 8'h77, 7'd12);
    commit(0, "R9 window", 0, 0, 0, 0);
    commit(0, "R9 empty after busy", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    load(4, 8'h44, 7'd8); load(8, 8'h88, 7'd8);
    txn(0, 0, 0, 0);
    load(10, 8'hAA, 7'd21);
    commit(0, "R10 clear", 0, 0, 0, 0);

    txn(0, 0, 0, 0);
    load(1, 8'h01, 7'd15);
    commit(0, "R11 same cycle", 1, 14, 8'hE4, 7'd2);

    txn(0, 0, 0, 0);
    commit(0, "R11 only load", 1, 6, 8'h66, 7'd41);

    txn(1, 13, 8'hD3, 7'd57);
    load(2, 8'h02, 7'd1);
    commit(0, "R12 start with load", 0, 0, 0, 0);

    for (int t = 0; t < 40; t++) begin
      int k;
      txn(1'($urandom), OW'($urandom), 8'($urandom), RW'($urandom));
      k = $urandom_range(0, 36);
      for (int j = 0; j < k; j++) load(OW'($urandom), 8'($urandom), RW'($urandom));
      commit(($urandom % 4) == 0, "R2 random", 1'($urandom),
             OW'($urandom), 8'($urandom), RW'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule